// File: doc/BRIEF.md
# Elevator Car Unit Controller

This block is the motion and door sequencer for a single elevator car. Each cycle it compares the target floor, which comes from an external request resolver, with the floor the car is on now, which comes from floor sensing. From that comparison it drives the raise motor, the lower motor and the door. When the car arrives, it stops the motors and opens the door. A built-in hold counter keeps the door open for a fixed number of clock ticks. After that, the car returns to its resting state and is ready for the next target.

The outputs are a pure function of the registered state. Motion toward a target continues for as long as the target lies beyond the present floor in the direction of travel. Once the car reaches the target or passes it, the door opens. While the door is held open, the floor inputs are ignored.

Top module: `lift_car_ctrl`

## Requirements
- R1: A synchronous, active-high `rst` puts the block in the resting state. In that state, `door_open`=1, `motor_up`=0 and `motor_dn`=0.
- R2: In the resting state, on each clock edge the block does one of three things. If `req_floor` > `cur_floor`, it starts rising, so `motor_up`=1 after that edge. If `req_floor` < `cur_floor`, it starts lowering, so `motor_dn`=1. If the two are equal, it stays at rest.
- R3: While rising, the outputs are `motor_up`=1, `motor_dn`=0 and `door_open`=0. The block keeps rising on every edge at which `req_floor` > `cur_floor`.
- R4: While rising, an edge at which `req_floor` <= `cur_floor` moves the block to door hold. This includes the case where the car has already passed the target.
- R5: While lowering, the outputs are `motor_dn`=1, `motor_up`=0 and `door_open`=0. The block keeps lowering while `req_floor` < `cur_floor` and enters door hold on the first edge where this is false.
- R6: In door hold, the outputs are `door_open`=1 with both motors 0. Door hold lasts exactly DWELL+1 clock cycles (11 by default), whatever the floor inputs are, and then the block returns to rest. The hold counter is cleared whenever the block is not in door hold and never wraps.
- R7: `motor_up` and `motor_dn` are never 1 at the same time, and neither motor is on while `door_open`=1.
- R8: Floor numbers are unsigned FW-bit values (FW=4 by default). For example, a target of 15 with the car at floor 0 starts rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_floor | input | FW | Target floor from the request resolver |
| cur_floor | input | FW | Floor the car is on now |
| motor_up | output | 1 | Raise motor drive |
| motor_dn | output | 1 | Lower motor drive |
| door_open | output | 1 | Door open command |

## Verification
The bench sweeps every pair of target and start floor. It moves a modelled car one floor per cycle according to the motor outputs, and compares all three outputs against an arithmetic model on every cycle.

The corner cases it targets are as follows. An equal-floor request must never start a motor. A car that has passed its target must open the door rather than keep running. A target of 15 against floor 0 must not be read as signed. The door hold must last exactly eleven cycles while the floor inputs demand motion. A design with an off-by-one in the hold counter would move the raise-motor edge by a cycle. A signed compare would drive the car the wrong way. A design that only watches for equality would overshoot forever.

// File: rtl/elev_pkg.sv
package elev_pkg;

    // Car sequencing states
    typedef enum logic [1:0] {
        ST_REST = 2'd0,
        ST_RISE = 2'd1,
        ST_LOWER = 2'd2,
        ST_HOLD = 2'd3
    } car_state_e;

    // Relation of target floor to present floor
    typedef enum logic [1:0] {
        REL_SAME  = 2'd0,
        REL_ABOVE = 2'd1,
        REL_BELOW = 2'd2
    } floor_rel_e;

    // Drive bundle decoded from the state
    typedef struct packed {
        logic up;
        logic dn;
        logic open;
        logic hold;
    } car_drive_t;

    function automatic car_drive_t drive_of(car_state_e s);
        car_drive_t d;
        d = '0;
        case (s)
            ST_REST:  d.open = 1'b1;
            ST_RISE:  d.up   = 1'b1;
            ST_LOWER: d.dn   = 1'b1;
            ST_HOLD: begin
                d.open = 1'b1;
                d.hold = 1'b1;
            end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/floor_cmp.sv
module floor_cmp
    import elev_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic [FW-1:0] req,
    input  logic [FW-1:0] cur,
    output floor_rel_e    rel
);
    // Unsigned magnitude comparison of target against present floor
    always_comb begin
        if (req > cur)
            rel = REL_ABOVE;
        else if (req < cur)
            rel = REL_BELOW;
        else
            rel = REL_SAME;
    end
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int DWELL = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int            TW    = $clog2(DWELL + 1);
    localparam logic [TW-1:0] CMAX  = '1;
    localparam logic [TW-1:0] LIMIT = TW'(DWELL);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != CMAX)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= LIMIT);

    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));                                   // R6
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));    // R6
    AST_TMR_SAT: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == CMAX) |=> (cnt == CMAX));                 // R6
endmodule

// File: rtl/car_seq.sv
module car_seq
    import elev_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  floor_rel_e rel,
    input  logic       dwell_done,
    output car_state_e state
);
    car_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_REST: begin
                if (rel == REL_ABOVE)
                    nxt = ST_RISE;
                else if (rel == REL_BELOW)
                    nxt = ST_LOWER;
                else
                    nxt = ST_REST;
            end
            ST_RISE:  nxt = (rel == REL_ABOVE) ? ST_RISE : ST_HOLD;
            ST_LOWER: nxt = (rel == REL_BELOW) ? ST_LOWER : ST_HOLD;
            ST_HOLD:  nxt = dwell_done ? ST_REST : ST_HOLD;
            default:  nxt = ST_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_REST;
        else
            state <= nxt;
    end

    AST_REST_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REST && rel == REL_ABOVE) |=> (state == ST_RISE));   // R2
    AST_RISE_ARRIVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RISE && rel != REL_ABOVE) |=> (state == ST_HOLD));   // R4
    AST_LOWER_KEEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOWER && rel == REL_BELOW) |=> (state == ST_LOWER)); // R5
    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && dwell_done) |=> (state == ST_REST));         // R6
endmodule

// File: rtl/lift_car_ctrl.sv
module lift_car_ctrl
    import elev_pkg::*;
#(
    parameter int FW    = 4,
    parameter int DWELL = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] req_floor,
    input  logic [FW-1:0] cur_floor,
    output logic          motor_up,
    output logic          motor_dn,
    output logic          door_open
);
    floor_rel_e rel;
    car_state_e state;
    car_drive_t drv;
    logic       dwell_done;

    floor_cmp #(.FW(FW)) u_cmp (
        .req (req_floor),
        .cur (cur_floor),
        .rel (rel)
    );

    dwell_timer #(.DWELL(DWELL)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (drv.hold),
        .done (dwell_done)
    );

    car_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .rel        (rel),
        .dwell_done (dwell_done),
        .state      (state)
    );

    assign drv       = drive_of(state);
    assign motor_up  = drv.up;
    assign motor_dn  = drv.dn;
    assign door_open = drv.open;

    AST_MOTOR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(motor_up && motor_dn));                                // R7
    AST_DOOR_SAFE: assert property (@(posedge clk) disable iff (rst)
        door_open |-> !(motor_up || motor_dn));                  // R7
    AST_RISE_OUT: assert property (@(posedge clk) disable iff (rst)
        (motor_up && req_floor > cur_floor) |=> motor_up);       // R3
endmodule

// File: tb/sim_lift_car_ctrl.sv
module sim_lift_car_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int FW    = 4;
    localparam int DWELL = 10;
    localparam int NFL   = 1 << FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [FW-1:0] req = '0;
    logic [FW-1:0] cur = '0;
    logic          motor_up, motor_dn, door_open;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // model: 0 rest, 1 rise, 2 lower, 3 hold
    int m_st = 0;
    int m_t  = 0;

    lift_car_ctrl #(.FW(FW), .DWELL(DWELL)) u0 (
        .clk(clk), .rst(rst), .req_floor(req), .cur_floor(cur),
        .motor_up(motor_up), .motor_dn(motor_dn), .door_open(door_open)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, string what, logic a, logic e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b (req=%0d cur=%0d)",
                     tag, what, a, e, req, cur);
        end
    endtask

    task automatic chk_model();
        string tag;
        case (m_st)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R5";
            default: tag = "R6";
        endcase
        chk(tag, "motor_up", motor_up, m_st == 1);
        chk(tag, "motor_dn", motor_dn, m_st == 2);
        chk(tag, "door_open", door_open, (m_st == 0) || (m_st == 3));
        chk("R7", "motor exclusive", motor_up & motor_dn, 1'b0);
    endtask

    // advance one clock; model evaluated on the inputs seen at the edge
    task automatic tick();
        int n;
        int nt;
        n = m_st;
        nt = 0;
        case (m_st)
            0: n = (req > cur) ? 1 : ((req < cur) ? 2 : 0);
            1: n = (req > cur) ? 1 : 3;
            2: n = (req < cur) ? 2 : 3;
            default: begin
                if (m_t >= DWELL) n = 0;
                else begin n = 3; nt = m_t + 1; end
            end
        endcase
        @(posedge clk);
        m_st = n;
        m_t  = nt;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0;
        m_t  = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1", "door_open", door_open, 1'b1);
        chk("R1", "motor_up", motor_up, 1'b0);
        chk("R1", "motor_dn", motor_dn, 1'b0);

        // R8: top target from bottom floor must rise
        req = 4'd15; cur = 4'd0;
        tick();
        chk("R8", "motor_up", motor_up, 1'b1);
        chk("R8", "motor_dn", motor_dn, 1'b0);

        // R4: rising car passes its target
        do_reset();
        req = 4'd5; cur = 4'd2;
        tick();
        cur = 4'd7;
        tick();
        chk("R4", "door_open", door_open, 1'b1);
        chk("R4", "motor_up", motor_up, 1'b0);

        // R5: lowering car passes its target
        do_reset();
        req = 4'd3; cur = 4'd9;
        tick();
        chk("R5", "motor_dn", motor_dn, 1'b1);
        cur = 4'd1;
        tick();
        chk("R5", "door_open", door_open, 1'b1);
        chk("R5", "motor_dn", motor_dn, 1'b0);

        // R6: hold lasts DWELL+1 cycles with inputs demanding motion
        begin
            int open_cycles;
            open_cycles = 0;
            req = 4'd15; cur = 4'd0;
            while (!motor_up && open_cycles < 40) begin
                open_cycles++;
                tick();
            end
            // DWELL+1 hold cycles, one rest cycle, then rise
            total++;
            if (open_cycles != DWELL + 2) begin
                bad++;
                $display("FAIL R6 hold length actual=%0d expected=%0d",
                         open_cycles, DWELL + 2);
            end
        end

        // Sweep every target/start pair with a moving car
        for (int r = 0; r < NFL; r++) begin
            for (int c = 0; c < NFL; c++) begin
                int guard;
                do_reset();
                req = FW'(r);
                cur = FW'(c);
                tick();
                chk_model();
                guard = 0;
                while (m_st != 0 && guard < 60) begin
                    if (motor_up) cur = cur + 1'b1;
                    else if (motor_dn) cur = cur - 1'b1;
                    tick();
                    chk_model();
                    guard++;
                end
                // R2: idle with equal floors stays at rest
                tick();
                chk_model();
                chk("R2", "idle door_open", door_open, 1'b1);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule